// File: doc/BRIEF.md
# Co-processor Shared-Memory Bus Handover Controller

This block decides which of two processors drives a shared DRAM bus: the host processor or an add-on co-processor. It holds three bits of state: the host's memory-on request, a flag saying the host currently holds the bus, and the bus enable that gates the host's memory and system-I/O decode. The host sets its memory-on request through a port write; the co-processor takes or hands back the bus through writes to its own port, where two active-low bits carry the capture and release requests.

While the host holds the bus, the enable tracks the host's memory-on bit. A capture clears both the ownership flag and the enable. A release gives the bus back and loads the enable from the memory-on request, so a host write made while the co-processor held the bus takes effect on hand-back. The block also produces a status byte the co-processor reads, and decodes a 4-bit segment number into a system-I/O enable and its complement, a DRAM enable.

Top module: `cpbus_arbiter`

## Requirements
- R1: After reset the memory-on request, the host-ownership flag and the bus enable are all 1, so status bit 0 reads 0.
- R2: A host write (host_wr high at a rising edge) stores host_wdata bit 4 as the memory-on request; while the host holds the bus, the enable takes that value at the same edge.
- R3: While the co-processor holds the bus, host writes change only the memory-on request; the enable stays 0.
- R4: A co-processor write with cop_wdata bit 0 low is a release: the host-ownership flag becomes 1 and the enable is loaded from the memory-on request.
- R5: A co-processor write with bit 0 high and bit 6 low is a capture: the ownership flag and the enable both become 0.
- R6: When bits 0 and 6 are both low, the release takes priority over the capture.
- R7: A co-processor write with bits 0 and 6 both high leaves ownership and enable unchanged.
- R8: When a host write and a co-processor write share an edge, the host write is applied first and the co-processor write last; a release then loads the memory-on value just written.
- R9: The status byte reads bits 7 and 6 as 1, bits 5 to 1 as peer_bits 4 to 0, and bit 0 as the inverse of the enable.
- R10: sys_io_en is 1 exactly when the enable is 1 and seg is not 4'b1111; dram_en is always the inverse of sys_io_en.
- R11: Data presented without its write strobe has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host port write strobe |
| host_wdata | input | 8 | Host port write data; bit 4 is the memory-on request |
| cop_wr | input | 1 | Co-processor port write strobe |
| cop_wdata | input | 8 | Co-processor port data; bit 0 low releases, bit 6 low captures |
| peer_bits | input | 5 | Companion port bits copied into status bits 5..1 |
| seg | input | 4 | Current segment number |
| status | output | 8 | Ownership status byte for the co-processor |
| sys_io_en | output | 1 | System-I/O decode enable |
| dram_en | output | 1 | DRAM enable, complement of sys_io_en |

## Verification
The bench targets host writes while the co-processor holds the bus: a design letting the enable follow the host bit regardless of ownership would hand the bus back early. It drives both request bits low at once, which a design with inverted priority would turn into a capture, and both high, which a careless decode would treat as a request. Same-edge host and co-processor writes expose a design that loads the old memory-on value on release, and a full segment sweep at both enable levels catches a wrong top-segment match or a DRAM enable that is not the exact complement.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

    typedef enum logic [1:0] {
        REQ_NONE    = 2'd0,
        REQ_RELEASE = 2'd1,
        REQ_CAPTURE = 2'd2
    } cop_req_e;

    typedef struct packed {
        logic mem_on;    // host's memory-on request
        logic host_own;  // host currently holds the bus
        logic host_en;   // bus enable gating host decode
    } own_state_t;

endpackage

// File: rtl/cpbus_req_decode.sv
module cpbus_req_decode
    import cpbus_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int REL_BIT = 0,
    parameter int CAP_BIT = 6
) (
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    output cop_req_e          req
);
    logic unused_bits;
    assign unused_bits = ^data;

    always_comb begin
        req = REQ_NONE;
        if (wr) begin
            // release outranks capture
            if (!data[REL_BIT])      req = REQ_RELEASE;
            else if (!data[CAP_BIT]) req = REQ_CAPTURE;
        end
    end
endmodule

// File: rtl/cpbus_own_core.sv
module cpbus_own_core
    import cpbus_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MEM_ON_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  cop_req_e          cop_req,
    output own_state_t        st
);
    own_state_t st_d, st_q;
    logic unused_bits;
    assign unused_bits = ^host_wdata;

    always_comb begin
        st_d = st_q;
        // host write first
        if (host_wr) begin
            st_d.mem_on = host_wdata[MEM_ON_BIT];
            if (st_q.host_own) st_d.host_en = host_wdata[MEM_ON_BIT];
        end
        // co-processor write last
        case (cop_req)
            REQ_RELEASE: begin
                st_d.host_own = 1'b1;
                st_d.host_en  = st_d.mem_on;
            end
            REQ_CAPTURE: begin
                st_d.host_own = 1'b0;
                st_d.host_en  = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mem_on: 1'b1, host_own: 1'b1, host_en: 1'b1};
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/cpbus_seg_decode.sv
module cpbus_seg_decode #(
    parameter int SEG_W = 4
) (
    input  logic             host_en,
    input  logic [SEG_W-1:0] seg,
    output logic             sys_io_en,
    output logic             dram_en
);
    logic [SEG_W:0] ones_chain;
    assign ones_chain[0] = 1'b1;

    for (genvar i = 0; i < SEG_W; i++) begin : g_chain
        assign ones_chain[i+1] = ones_chain[i] & seg[i];
    end

    assign sys_io_en = host_en & ~ones_chain[SEG_W];
    assign dram_en   = ~sys_io_en;
endmodule

// File: rtl/cpbus_status_pack.sv
module cpbus_status_pack #(
    parameter int DATA_W = 8
) (
    input  logic              host_en,
    input  logic [DATA_W-4:0] peer,
    output logic [DATA_W-1:0] status
);
    localparam int PEER_W = DATA_W - 3;

    assign status[0] = ~host_en;
    for (genvar i = 0; i < PEER_W; i++) begin : g_peer
        assign status[i+1] = peer[i];
    end
    assign status[DATA_W-1:DATA_W-2] = 2'b11;
endmodule

// File: rtl/cpbus_arbiter.sv
module cpbus_arbiter
    import cpbus_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SEG_W      = 4,
    parameter int MEM_ON_BIT = 4,
    parameter int REL_BIT    = 0,
    parameter int CAP_BIT    = 6,
    localparam int PEER_W    = DATA_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cop_wr,
    input  logic [DATA_W-1:0] cop_wdata,
    input  logic [PEER_W-1:0] peer_bits,
    input  logic [SEG_W-1:0]  seg,
    output logic [DATA_W-1:0] status,
    output logic              sys_io_en,
    output logic              dram_en
);
    cop_req_e   cop_req;
    own_state_t st;
    logic       own_flag, en_flag, mem_flag;

    cpbus_req_decode #(.DATA_W(DATA_W), .REL_BIT(REL_BIT), .CAP_BIT(CAP_BIT)) u_req (
        .wr(cop_wr), .data(cop_wdata), .req(cop_req)
    );

    cpbus_own_core #(.DATA_W(DATA_W), .MEM_ON_BIT(MEM_ON_BIT)) u_core (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .cop_req(cop_req), .st(st)
    );

    assign own_flag = st.host_own;
    assign en_flag  = st.host_en;
    assign mem_flag = st.mem_on;

    cpbus_seg_decode #(.SEG_W(SEG_W)) u_seg (
        .host_en(en_flag), .seg(seg), .sys_io_en(sys_io_en), .dram_en(dram_en)
    );

    cpbus_status_pack #(.DATA_W(DATA_W)) u_stat (
        .host_en(en_flag), .peer(peer_bits), .status(status)
    );
endmodule

// File: rtl/cpbus_arbiter_chk.sv
module cpbus_arbiter_chk #(
    parameter int DATA_W     = 8,
    parameter int SEG_W      = 4,
    parameter int MEM_ON_BIT = 4,
    parameter int REL_BIT    = 0,
    parameter int CAP_BIT    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              cop_wr,
    input logic [DATA_W-1:0] cop_wdata,
    input logic [SEG_W-1:0]  seg,
    input logic [DATA_W-1:0] status,
    input logic              sys_io_en,
    input logic              dram_en,
    input logic              own_flag,
    input logic              en_flag,
    input logic              mem_flag
);
    // R2: host-held bus follows the host bit
    a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && own_flag && !cop_wr) |=> (en_flag == $past(host_wdata[MEM_ON_BIT])));

    // R3: co-processor-held bus stays disabled unless released
    a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_flag && !(cop_wr && !cop_wdata[REL_BIT])) |=> !en_flag);

    // R4 and R6: release returns the bus with enable equal to memory-on
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_wr && !cop_wdata[REL_BIT]) |=> (own_flag && en_flag == mem_flag));

    // R5: capture drops ownership and enable
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_wr && cop_wdata[REL_BIT] && !cop_wdata[CAP_BIT]) |=> (!own_flag && !en_flag));

    // R7 and R11: no request, no host write: nothing moves
    a_r7_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !(cop_wr && !(cop_wdata[REL_BIT] && cop_wdata[CAP_BIT])))
        |=> ($stable(own_flag) && $stable(en_flag) && $stable(mem_flag)));

    // R9: fixed status bits and busy bit
    a_r9_status: assert property (@(posedge clk) disable iff (!rst_n)
        (status[DATA_W-1:DATA_W-2] == 2'b11) && (status[0] == !en_flag));

    // R10: enables are complementary and the top segment blocks system I/O
    a_r10_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_io_en != dram_en) && (sys_io_en == (en_flag && (seg != {SEG_W{1'b1}}))));
endmodule

bind cpbus_arbiter cpbus_arbiter_chk #(
    .DATA_W(DATA_W), .SEG_W(SEG_W), .MEM_ON_BIT(MEM_ON_BIT),
    .REL_BIT(REL_BIT), .CAP_BIT(CAP_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .cop_wr(cop_wr), .cop_wdata(cop_wdata), .seg(seg), .status(status),
    .sys_io_en(sys_io_en), .dram_en(dram_en),
    .own_flag(own_flag), .en_flag(en_flag), .mem_flag(mem_flag)
);

// File: tb/cpbus_arbiter_tb.sv
module cpbus_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       cop_wr = 1'b0;
    logic [7:0] cop_wdata = 8'hFF;
    logic [4:0] peer_bits = 5'b10101;
    logic [3:0] seg = 4'h0;
    logic [7:0] status;
    logic       sys_io_en, dram_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    // requirement-level model of the expected state
    bit exp_mem = 1'b1, exp_own = 1'b1, exp_en = 1'b1;

    always #10 clk = ~clk;

    cpbus_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .cop_wr(cop_wr), .cop_wdata(cop_wdata), .peer_bits(peer_bits), .seg(seg),
        .status(status), .sys_io_en(sys_io_en), .dram_en(dram_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // status and decode against the model (R9, R10)
    task automatic chk_state(input string req);
        chk(req, status, {2'b11, peer_bits, ~exp_en});
        chk(req, {7'd0, sys_io_en}, {7'd0, exp_en && (seg != 4'hF)});
        chk(req, {7'd0, dram_en}, {7'd0, !(exp_en && (seg != 4'hF))});
    endtask

    // one edge of stimulus; host write modelled first, co-processor last (R8)
    task automatic step(input bit hw, input logic [7:0] hd, input bit cw, input logic [7:0] cd);
        @(negedge clk);
        host_wr = hw; host_wdata = hd; cop_wr = cw; cop_wdata = cd;
        if (hw) begin
            exp_mem = hd[4];
            if (exp_own) exp_en = hd[4];
        end
        if (cw) begin
            if (!cd[0]) begin exp_own = 1'b1; exp_en = exp_mem; end
            else if (!cd[6]) begin exp_own = 1'b0; exp_en = 1'b0; end
        end
        @(negedge clk);
        host_wr = 1'b0; cop_wr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", status, 8'hEA);
        chk("R1", {7'd0, sys_io_en}, 8'd1);
        seg = 4'hF; #1;
        chk("R10", {7'd0, sys_io_en}, 8'd0);
        chk("R10", {7'd0, dram_en}, 8'd1);
        seg = 4'h0;
    endtask

    task automatic t_host_follow();
        step(1, 8'hEF, 0, 8'hFF); chk("R2", {7'd0, status[0]}, 8'd1); chk_state("R2");
        step(1, 8'h10, 0, 8'hFF); chk("R2", {7'd0, status[0]}, 8'd0); chk_state("R2");
    endtask

    task automatic t_capture_hold();
        step(0, 8'h00, 1, 8'hBF); chk("R5", {7'd0, status[0]}, 8'd1); chk_state("R5");
        step(1, 8'h10, 0, 8'hFF); chk("R3", {7'd0, status[0]}, 8'd1); chk_state("R3");
        step(1, 8'h00, 0, 8'hFF); chk("R3", {7'd0, dram_en}, 8'd1);
        step(0, 8'h00, 1, 8'hFE); chk("R4", {7'd0, status[0]}, 8'd1); chk_state("R4");
        step(1, 8'h10, 0, 8'hFF); chk("R4", {7'd0, status[0]}, 8'd0); chk_state("R4");
    endtask

    task automatic t_priority();
        step(0, 8'h00, 1, 8'hBF); chk("R5", {7'd0, status[0]}, 8'd1);
        step(0, 8'h00, 1, 8'h00); chk("R6", {7'd0, status[0]}, 8'd0); chk_state("R6");
        step(0, 8'h00, 1, 8'hFF); chk("R7", {7'd0, status[0]}, 8'd0);
        step(0, 8'h00, 1, 8'hBF);
        step(0, 8'h00, 1, 8'hFF); chk("R7", {7'd0, status[0]}, 8'd1);
        step(1, 8'h10, 0, 8'hFF); chk("R7", {7'd0, status[0]}, 8'd1);
        step(0, 8'h00, 1, 8'h40); chk("R6", {7'd0, status[0]}, 8'd0); chk_state("R6");
    endtask

    task automatic t_same_edge();
        step(0, 8'h00, 1, 8'hBF);
        step(1, 8'h00, 1, 8'hFE); chk("R8", {7'd0, status[0]}, 8'd1); chk_state("R8");
        step(1, 8'h10, 1, 8'hBF); chk("R8", {7'd0, status[0]}, 8'd1);
        step(0, 8'h00, 1, 8'hFE); chk("R8", {7'd0, status[0]}, 8'd0); chk_state("R8");
        step(1, 8'h00, 1, 8'hBF); chk("R8", {7'd0, status[0]}, 8'd1);
        step(1, 8'h10, 1, 8'hFE); chk("R8", {7'd0, status[0]}, 8'd0);
    endtask

    task automatic t_no_strobe();
        @(negedge clk); host_wdata = 8'h00; cop_wdata = 8'hBE;
        repeat (3) @(negedge clk);
        chk("R11", {7'd0, status[0]}, 8'd0);
        step(1, 8'h00, 0, 8'hFF);
        @(negedge clk); host_wdata = 8'h10; cop_wdata = 8'h00;
        repeat (3) @(negedge clk);
        chk("R11", {7'd0, status[0]}, 8'd1);
        step(1, 8'h10, 0, 8'hFF); chk_state("R11");
    endtask

    task automatic t_decode_status();
        for (int e = 0; e < 2; e++) begin
            step(1, (e == 1) ? 8'h10 : 8'h00, 0, 8'hFF);
            for (int s = 0; s < 16; s++) begin
                seg = 4'(s); #1;
                chk_state("R10");
            end
        end
        seg = 4'h3;
        for (int p = 0; p < 32; p += 7) begin
            peer_bits = 5'(p); #1;
            chk_state("R9");
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_host_follow();
        t_capture_hold();
        t_priority();
        t_same_edge();
        t_no_strobe();
        t_decode_status();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule